// File: doc/BRIEF.md
# Dual-Mode FM0 / Manchester Line Encoder

This block is a synchronous serial line encoder for a short-range vehicular radio baseband. It takes one data bit per bit period and drives a single line with either FM0 (bi-phase space) or Manchester code. Which code is used is chosen per bit by a mode input. The block runs from one clock at twice the bit rate. An internal half-bit toggle splits every bit period into a first and a second half-bit symbol. Both codes use the same single state flop and the same registered output path. The line level is always taken from a flop, so it cannot glitch.

A source offers a bit by holding `bit_stb` high with `bit_data` valid. The bit is taken on the clock edge that opens a new bit period, and `bit_ack` then pulses for one cycle. If no bit is offered at a bit boundary, a fill bit is encoded instead. A synchronous clear (`clr`), separate from the mode input, reinitialises the encoder to a known line level and phase.

Top module: `line_encoder`

## Requirements
- R1: During reset, and right after it, `line_out` is 1 and `bit_ack` is 0. The first rising edge after reset is released opens a bit period.
- R2: A bit is taken only on an edge that opens a bit period. `bit_ack` is high for exactly one cycle after that edge. During that cycle `line_out` shows the first half-bit symbol, and in the following cycle it shows the second.
- R3: In FM0 (`mode_sel` = 0), the first half-bit symbol is the inverse of the previous bit's second symbol, so the line changes level at every bit start.
- R4: In FM0, a data 0 gives a second symbol that is the inverse of the first, and a data 1 gives a second symbol equal to the first.
- R5: After reset or clear, the FM0 state holds a stored level of 1. A first bit of 0 therefore encodes as 0 then 1, and a first bit of 1 encodes as 0 then 0.
- R6: In Manchester (`mode_sel` = 1), the first symbol is the inverse of the data and the second symbol equals the data.
- R7: `mode_sel` and `bit_data` are sampled only at a bit boundary. Changing them during a bit has no effect on that bit's second symbol.
- R8: In Manchester mode the shared state flop is held at 0. An FM0 bit that directly follows a Manchester bit therefore begins with a first symbol of 1.
- R9: When `bit_stb` is low at a bit boundary, a fill bit of value 1 is encoded in the current mode and `bit_ack` stays 0.
- R10: While `clr` is high, `line_out` goes to 1 on the next edge, `bit_ack` is 0, and any bit in progress is dropped. The first edge after `clr` falls opens a new bit period, with the FM0 stored level set to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the bit rate |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Synchronous clear / initialise, separate from mode |
| mode_sel | input | 1 | 0 = FM0, 1 = Manchester; sampled at bit boundaries |
| bit_stb | input | 1 | Source offers a bit |
| bit_data | input | 1 | Data bit offered |
| line_out | output | 1 | Registered encoded line level |
| bit_ack | output | 1 | One-cycle pulse: offered bit taken |

## Verification
The bench checks each half-bit pair against its own model of both codes across mixed bit patterns. It targets four corner cases.
- **State after clear.** A design that initialised the stored level wrongly would invert the first FM0 bit's symbols.
- **Manchester to FM0.** A design that did not hold the shared flop at 0 in Manchester mode would start the first following FM0 bit at the wrong level.
- **Mid-bit change of mode or data.** A design that sampled these inputs on every edge would corrupt the second symbol of the bit in progress.
- **Idle boundary and mid-bit clear.** At a boundary with no strobe, a wrong design would emit a stale bit or a spurious acknowledge. On a clear in mid-bit, it would leave the line at a stale level or misalign the next bit period.

// File: rtl/enc_line_pkg.sv
// Shared types for the dual-mode line encoder.
package enc_line_pkg;
    typedef enum logic {
        MODE_FM0 = 1'b0,
        MODE_MAN = 1'b1
    } line_mode_e;
endpackage

// File: rtl/enc_bit_sequencer.sv
// Half-bit sequencer: toggles between the first and second half of each bit
// period, samples the offered bit and the mode at bit boundaries, and raises
// the acknowledge pulse. Assumes the clock runs at twice the bit rate.
module enc_bit_sequencer
    import enc_line_pkg::*;
#(
    parameter logic FILL_BIT = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       bit_stb,
    input  logic       bit_data,
    input  logic       mode_sel,
    output logic       at_boundary,
    output logic       eff_bit,
    output line_mode_e eff_mode,
    output logic       second_half,
    output logic       cur_bit,
    output line_mode_e mode_q,
    output logic       bit_ack
);
    logic sel_bit;

    // Offered bit, or the fill bit when nothing is offered.
    assign sel_bit     = bit_stb ? bit_data : FILL_BIT;
    // The next edge opens a new bit when the second half is on the line.
    assign at_boundary = second_half;

    // Bit and mode that the next symbol is built from.
    always_comb begin
        eff_bit  = at_boundary ? sel_bit : cur_bit;
        eff_mode = at_boundary ? line_mode_e'(mode_sel) : mode_q;
    end

    // Phase toggle, per-bit sampling and acknowledge pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            second_half <= 1'b1;
            cur_bit     <= FILL_BIT;
            mode_q      <= MODE_FM0;
            bit_ack     <= 1'b0;
        end else if (clr) begin
            second_half <= 1'b1;
            bit_ack     <= 1'b0;
        end else begin
            second_half <= ~second_half;
            if (second_half) begin
                cur_bit <= sel_bit;
                mode_q  <= line_mode_e'(mode_sel);
                bit_ack <= bit_stb;
            end else begin
                bit_ack <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/enc_state_flop.sv
// Single state flop shared by both codes. It holds the last second-half
// symbol for FM0 and is forced to 0 while Manchester is in use, so the
// shared XOR reduces to the data bit. Assumes clr is driven by the system
// controller independently of the mode.
module enc_state_flop
    import enc_line_pkg::*;
#(
    parameter logic CLR_LEVEL = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  line_mode_e eff_mode,
    input  logic       at_boundary,
    input  logic       next_b,
    output logic       prev_b
);
    // Capture the second symbol at mid-bit, clear in Manchester, init on clr.
    always_ff @(posedge clk) begin
        if (!rst_n)                   prev_b <= CLR_LEVEL;
        else if (clr)                 prev_b <= CLR_LEVEL;
        else if (eff_mode == MODE_MAN) prev_b <= 1'b0;
        else if (!at_boundary)        prev_b <= next_b;
    end
endmodule

// File: rtl/enc_symbol_path.sv
// Shared symbol datapath: one select-and-invert term for the first half,
// one XOR term for the second half, and a registered line output.
// Assumes prev_b is 0 whenever the mode is Manchester.
module enc_symbol_path
    import enc_line_pkg::*;
#(
    parameter logic CLR_LEVEL = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       at_boundary,
    input  logic       eff_bit,
    input  line_mode_e eff_mode,
    input  logic       prev_b,
    output logic       next_b,
    output logic       line_q
);
    logic first_sym;

    // First half: inverse of stored level (FM0) or of the data (Manchester).
    assign first_sym = ~((eff_mode == MODE_FM0) ? prev_b : eff_bit);
    // Second half: data XOR stored level; the stored level is 0 in Manchester.
    assign next_b    = eff_bit ^ prev_b;

    // Glitch-free line register.
    always_ff @(posedge clk) begin
        if (!rst_n)           line_q <= CLR_LEVEL;
        else if (clr)         line_q <= CLR_LEVEL;
        else if (at_boundary) line_q <= first_sym;
        else                  line_q <= next_b;
    end
endmodule

// File: rtl/line_encoder.sv
// Dual-mode FM0 / Manchester line encoder top. One clock at twice the bit
// rate; each bit becomes two half-bit symbols on a registered line output.
module line_encoder
    import enc_line_pkg::*;
#(
    parameter logic FILL_BIT  = 1'b1,
    parameter logic CLR_LEVEL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic mode_sel,
    input  logic bit_stb,
    input  logic bit_data,
    output logic line_out,
    output logic bit_ack
);
    logic       seq_boundary;
    logic       seq_eff_bit;
    line_mode_e seq_eff_mode;
    logic       seq_second_half;
    logic       seq_cur_bit;
    line_mode_e seq_mode_q;
    logic       st_prev_b;
    logic       dp_next_b;

    enc_bit_sequencer #(.FILL_BIT(FILL_BIT)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr         (clr),
        .bit_stb     (bit_stb),
        .bit_data    (bit_data),
        .mode_sel    (mode_sel),
        .at_boundary (seq_boundary),
        .eff_bit     (seq_eff_bit),
        .eff_mode    (seq_eff_mode),
        .second_half (seq_second_half),
        .cur_bit     (seq_cur_bit),
        .mode_q      (seq_mode_q),
        .bit_ack     (bit_ack)
    );

    enc_state_flop #(.CLR_LEVEL(CLR_LEVEL)) u_state (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr         (clr),
        .eff_mode    (seq_eff_mode),
        .at_boundary (seq_boundary),
        .next_b      (dp_next_b),
        .prev_b      (st_prev_b)
    );

    enc_symbol_path #(.CLR_LEVEL(CLR_LEVEL)) u_path (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr         (clr),
        .at_boundary (seq_boundary),
        .eff_bit     (seq_eff_bit),
        .eff_mode    (seq_eff_mode),
        .prev_b      (st_prev_b),
        .next_b      (dp_next_b),
        .line_q      (line_out)
    );
endmodule

// File: rtl/line_encoder_checker.sv
// Property checker for line_encoder, attached with bind.
module line_encoder_checker
    import enc_line_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       clr,
    input logic       line_out,
    input logic       bit_ack,
    input logic       second_half,
    input logic       cur_bit,
    input line_mode_e mode_q
);
    // R2: acknowledge is a single-cycle pulse
    a_r2_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
        bit_ack |=> !bit_ack);

    // R2: acknowledge only while the first symbol is on the line
    a_r2_ack_first_half: assert property (@(posedge clk) disable iff (!rst_n)
        bit_ack |-> !second_half);

    // R3: FM0 level change at every bit start
    a_r3_fm0_start_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (!second_half && mode_q == MODE_FM0 && $past(mode_q) == MODE_FM0)
        |-> (line_out != $past(line_out)));

    // R4: FM0 mid-bit change only for data 0
    a_r4_fm0_mid: assert property (@(posedge clk) disable iff (!rst_n)
        (second_half && !$past(second_half) && !$past(clr) && mode_q == MODE_FM0)
        |-> (line_out == ($past(line_out) ^ ~cur_bit)));

    // R6: Manchester second symbol equals data, with a mid-bit transition
    a_r6_man_mid: assert property (@(posedge clk) disable iff (!rst_n)
        (second_half && !$past(second_half) && !$past(clr) && mode_q == MODE_MAN)
        |-> (line_out == cur_bit && line_out != $past(line_out)));

    // R7: the latched mode only changes when a bit opens
    a_r7_mode_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mode_q) |-> !second_half);

    // R10: clear drives the line to its initial level and suppresses acknowledge
    a_r10_clear_level: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (line_out && !bit_ack && second_half));
endmodule

bind line_encoder line_encoder_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr         (clr),
    .line_out    (line_out),
    .bit_ack     (bit_ack),
    .second_half (seq_second_half),
    .cur_bit     (seq_cur_bit),
    .mode_q      (seq_mode_q)
);

// File: tb/tb_line_encoder.sv
// Directed bench for line_encoder with an independent model of both codes.
module tb_line_encoder;
    localparam time CLK_PERIOD = 10ns;

    logic clk = 1'b0;
    logic rst_n, clr, mode_sel, bit_stb, bit_data;
    logic line_out, bit_ack;

    int   n_checks = 0;
    int   n_fails  = 0;
    bit   done     = 1'b0;
    logic ref_b;   // model of the stored FM0 level

    line_encoder dut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .mode_sel(mode_sel),
        .bit_stb(bit_stb), .bit_data(bit_data),
        .line_out(line_out), .bit_ack(bit_ack)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // Reference code model: returns the two symbols and updates ref_b.
    task automatic model(input logic d, input logic m, output logic a, output logic b);
        if (m == 1'b0) begin
            a = ~ref_b; b = d ^ ref_b; ref_b = b;
        end else begin
            a = ~d; b = d; ref_b = 1'b0;
        end
    endtask

    // Offer a bit, wait for acknowledge, check both symbols.
    task automatic send_bit(input logic d, input logic m, input string req);
        logic ea, eb;
        bit_data = d; mode_sel = m; bit_stb = 1'b1;
        for (int n = 0; n < 8; n++) begin
            @(negedge clk);
            if (bit_ack) break;
        end
        check({req, " ack"}, bit_ack, 1'b1);
        model(d, m, ea, eb);
        check({req, " first symbol"}, line_out, ea);
        bit_stb = 1'b0;
        @(negedge clk);
        check({req, " second symbol"}, line_out, eb);
        check("R2 ack single cycle", bit_ack, 1'b0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; clr = 1'b0; mode_sel = 1'b0; bit_stb = 1'b0; bit_data = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 line in reset", line_out, 1'b1);
        check("R1 ack in reset", bit_ack, 1'b0);
        rst_n = 1'b1;
        ref_b = 1'b1;
        check("R1 line after reset", line_out, 1'b1);
    endtask

    task automatic t_fm0_first();
        do_reset();
        send_bit(1'b0, 1'b0, "R5 first FM0 bit 0");
        do_reset();
        send_bit(1'b1, 1'b0, "R5 first FM0 bit 1");
    endtask

    task automatic t_fm0_stream();
        logic [15:0] pat = 16'b1011_0010_0111_1000;
        do_reset();
        for (int i = 0; i < 16; i++) send_bit(pat[i], 1'b0, "R3 R4 FM0 stream");
    endtask

    task automatic t_manchester();
        logic [11:0] pat = 12'b0110_1100_1010;
        do_reset();
        for (int i = 0; i < 12; i++) send_bit(pat[i], 1'b1, "R6 Manchester stream");
    endtask

    task automatic t_mode_switch();
        do_reset();
        send_bit(1'b1, 1'b0, "R8 FM0 lead");
        send_bit(1'b1, 1'b1, "R8 Manchester");
        send_bit(1'b1, 1'b0, "R8 FM0 after Manchester");
        send_bit(1'b0, 1'b0, "R8 FM0 follow");
        send_bit(1'b0, 1'b1, "R8 back to Manchester");
    endtask

    task automatic t_mid_bit_change();
        logic ea, eb;
        do_reset();
        send_bit(1'b1, 1'b0, "R7 lead");
        bit_data = 1'b0; mode_sel = 1'b0; bit_stb = 1'b1;
        @(negedge clk);
        check("R7 ack", bit_ack, 1'b1);
        model(1'b0, 1'b0, ea, eb);
        check("R7 first symbol", line_out, ea);
        bit_stb = 1'b0; bit_data = 1'b1; mode_sel = 1'b1;   // mid-bit change
        @(negedge clk);
        check("R7 second symbol ignores mid-bit change", line_out, eb);
        send_bit(1'b0, 1'b1, "R7 next bit uses new mode");
    endtask

    task automatic t_fill(input logic m);
        logic ea, eb;
        do_reset();
        send_bit(1'b0, m, "R9 lead");
        bit_stb = 1'b0; mode_sel = m;
        @(negedge clk);
        model(1'b1, m, ea, eb);
        check("R9 no ack on fill", bit_ack, 1'b0);
        check("R9 fill first symbol", line_out, ea);
        @(negedge clk);
        check("R9 fill second symbol", line_out, eb);
        send_bit(1'b0, m, "R9 after fill");
    endtask

    task automatic t_clear();
        logic ea, eb;
        do_reset();
        send_bit(1'b1, 1'b0, "R10 lead");
        bit_data = 1'b0; bit_stb = 1'b1;
        @(negedge clk);
        model(1'b0, 1'b0, ea, eb);
        check("R10 ack before clear", bit_ack, 1'b1);
        check("R10 first symbol before clear", line_out, ea);
        bit_stb = 1'b0; clr = 1'b1;
        @(negedge clk);
        check("R10 line during clear", line_out, 1'b1);
        check("R10 ack during clear", bit_ack, 1'b0);
        @(negedge clk);
        check("R10 line held in clear", line_out, 1'b1);
        clr = 1'b0;
        ref_b = 1'b1;
        send_bit(1'b0, 1'b0, "R10 bit after clear");
        send_bit(1'b1, 1'b0, "R10 second bit after clear");
    endtask

    initial begin
        t_fm0_first();
        t_fm0_stream();
        t_manchester();
        t_mode_switch();
        t_mid_bit_change();
        t_fill(1'b0);
        t_fill(1'b1);
        t_clear();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule